// File: doc/BRIEF.md
# Processor State Interrupt Controller

The controller collects interrupt request pulses raised by a processor datapath, keeps each one as a sticky pending flag, and decides at each instruction boundary what to do with them. The processor runs in one of three modes: normal, control and zero-base. In normal mode, any pending request diverts execution to a handler when the current instruction finishes. In control mode, requests are only recorded. They force a branch to the fixed control entry `000094` when software tries to go back to normal mode. In zero-base mode, a fatal hardware or software condition does not branch. Instead it removes the processor clock enable and freezes every flag until an external reset.

The datapath drives the current mode, an instruction-complete strobe and a return-to-normal strobe. The handler reads the pending vector and clears the flags it has serviced with a clear mask. Outputs are a one-cycle branch request with its vector, a clock enable, the pending vector, and a one-cycle request to store a result descriptor after an invalid I/O initiate.

The sequencer has three named states. `SQ_RUN` is the idle state, where it waits for a boundary. `SQ_VEC` lasts one cycle and presents the branch. `SQ_HALT` is the frozen state, where the clock enable is withdrawn. Its transitions are:
- RUN to VEC, on a boundary with work pending.
- RUN to HALT, and VEC to HALT, on a fatal condition.
- VEC to RUN, after the branch cycle.
- HALT to HALT, until reset.

Top module: `psi_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after it, `pend_o` is 0, `clk_en_o` is 1, `branch_o` is 0, `vector_o` is 0 and `store_rd_o` is 0.
- R2: A high bit of `irq_i` sets the matching bit of `pend_o` from the next cycle. The bit stays set until the same bit of `clr_i` is high. The bit map is: 0 parity error, 1 address error, 2 instruction timeout, 3 unassigned opcode, 4 opcode needing an absent option, 5 invalid halt, 6 privileged instruction, 7 clock tick, 8 invalid I/O initiate.
- R3: In normal mode (`mode_i`=00), when `instr_done_i` is high and `pend_o` is nonzero, `branch_o` is high for exactly the next cycle, with `vector_o`=24'h000100. `pend_o` is left unchanged by the branch.
- R4: In control mode (`mode_i`=01, and also the unused code 11), `instr_done_i` never produces a branch.
- R5: In control mode, a `ret_norm_i` strobe with `pend_o` nonzero gives a one-cycle branch on the next cycle with `vector_o`=24'h000094. With `pend_o` zero, the strobe gives no branch.
- R6: In zero-base mode (`mode_i`=10), any of bits 0..5 of `irq_i` has the following effect. From the next cycle, `clk_en_o` is 0 and stays 0 until reset. While frozen, `pend_o` holds its value and ignores `irq_i` and `clr_i`, and no branch or store request is issued.
- R7: In zero-base mode, bit 6 (privileged instruction) of `irq_i` is ignored and does not set `pend_o`.
- R8: Clock tick and invalid I/O requests are recorded in every mode, but branch only through the normal-mode or return-to-normal paths. Fatal bits raised in normal or control mode are recorded without freezing.
- R9: A high bit 8 of `irq_i` makes `store_rd_o` high for exactly the next cycle, in any mode, unless the controller is frozen.
- R10: When a bit of `irq_i` and the same bit of `clr_i` are high in the same cycle, the set wins and the bit is pending afterwards.
- R11: While `branch_o` is high, a new boundary is not taken, so each branch lasts a single cycle. A freeze in that cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the only way out of the frozen state |
| mode_i | input | 2 | Processor mode: 00 normal, 01 control, 10 zero-base, 11 treated as control |
| irq_i | input | 9 | Interrupt request pulses, bit map as in R2 |
| instr_done_i | input | 1 | Current instruction completes this cycle |
| ret_norm_i | input | 1 | Software attempts to return from control to normal mode |
| clr_i | input | 9 | Clear mask for pending flags |
| branch_o | output | 1 | One-cycle branch request |
| vector_o | output | 24 | Branch target (BCD digits), zero when no branch |
| clk_en_o | output | 1 | Processor clock enable, low when frozen |
| pend_o | output | 9 | Pending interrupt flags |
| store_rd_o | output | 1 | Request to store an I/O result descriptor |

## Verification
The bench targets mode-sensitive decisions. If an instruction boundary branched in control mode, an unexpected `branch_o` would appear. If a return strobe with nothing pending branched, a spurious vector `000094` would appear. A privileged request taken in zero-base mode would show up as a stray pending bit. The frozen state gets particular attention: a design that let clears or new requests through, or that recovered without reset, would show a changed `pend_o` or a re-raised clock enable. Set-against-clear collisions and requests arriving during the branch cycle expose lost events and double branches. These are checked both directly and under long seeded random runs against a bench model.

// File: rtl/psi_pkg.sv
package psi_pkg;
    localparam int NSRC     = 9;
    localparam int B_PARITY = 0;
    localparam int B_ADDR   = 1;
    localparam int B_TMO    = 2;
    localparam int B_UNDEF  = 3;
    localparam int B_NOOPT  = 4;
    localparam int B_HALT   = 5;
    localparam int B_PRIV   = 6;
    localparam int B_TICK   = 7;
    localparam int B_IO     = 8;
    localparam int NFATAL   = 6;

    typedef enum logic [1:0] {
        PM_NORMAL  = 2'b00,
        PM_CONTROL = 2'b01,
        PM_ZERO    = 2'b10,
        PM_RSVD    = 2'b11
    } pmode_t;

    typedef enum logic [1:0] {
        SQ_RUN  = 2'b00,
        SQ_VEC  = 2'b01,
        SQ_HALT = 2'b10
    } sq_t;

    function automatic logic [NSRC-1:0] fatal_mask();
        logic [NSRC-1:0] m;
        m = '0;
        for (int i = 0; i < NFATAL; i++) m[i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/psi_pend.sv
module psi_pend
    import psi_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_i,
    input  logic [N-1:0] clr_i,
    input  logic         zb_i,
    input  logic         frz_i,
    output logic [N-1:0] pend_o,
    output logic         rd_o
);
    logic [N-1:0] pend_q;
    logic [N-1:0] set_v;
    logic         rd_q;

    always_comb begin
        set_v = irq_i;
        if (zb_i) set_v[B_PRIV] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            rd_q   <= 1'b0;
        end else if (frz_i) begin
            rd_q   <= 1'b0;
        end else begin
            pend_q <= (pend_q & ~clr_i) | set_v;
            rd_q   <= irq_i[B_IO];
        end
    end

    assign pend_o = pend_q;
    assign rd_o   = rd_q;

    // R6
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frz_i |=> $stable(pend_q));

    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i)));

    // R7
    priv_zb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zb_i && !pend_q[B_PRIV]) |=> !pend_q[B_PRIV]);

    // R9
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |-> $past(irq_i[B_IO]));
endmodule

// File: rtl/psi_fsm.sv
module psi_fsm
    import psi_pkg::*;
#(
    parameter int             N        = NSRC,
    parameter int             VW       = 24,
    parameter logic [VW-1:0]  NORM_VEC = 24'h000100,
    parameter logic [VW-1:0]  CTRL_VEC = 24'h000094
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pmode_t        mode_i,
    input  logic [N-1:0]  irq_i,
    input  logic          done_i,
    input  logic          ret_i,
    input  logic          any_pend_i,
    output logic          branch_o,
    output logic [VW-1:0] vec_o,
    output logic          halt_o
);
    localparam logic [N-1:0] FMASK = fatal_mask();

    sq_t           st_q, st_d;
    logic [VW-1:0] vec_q, vec_d;
    logic          fatal, take_norm, take_ctl;

    always_comb begin
        fatal     = (mode_i == PM_ZERO) && (|(irq_i & FMASK));
        take_norm = (mode_i == PM_NORMAL) && done_i && any_pend_i;
        take_ctl  = ((mode_i == PM_CONTROL) || (mode_i == PM_RSVD))
                    && ret_i && any_pend_i;
        st_d  = st_q;
        vec_d = vec_q;
        unique case (st_q)
            SQ_RUN: begin
                if (fatal) begin
                    st_d = SQ_HALT;
                end else if (take_norm) begin
                    st_d  = SQ_VEC;
                    vec_d = NORM_VEC;
                end else if (take_ctl) begin
                    st_d  = SQ_VEC;
                    vec_d = CTRL_VEC;
                end
            end
            SQ_VEC:  st_d = fatal ? SQ_HALT : SQ_RUN;
            SQ_HALT: st_d = SQ_HALT;
            default: st_d = SQ_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SQ_RUN;
            vec_q <= '0;
        end else begin
            st_q  <= st_d;
            vec_q <= vec_d;
        end
    end

    always_comb begin
        branch_o = (st_q == SQ_VEC);
        vec_o    = (st_q == SQ_VEC) ? vec_q : '0;
        halt_o   = (st_q == SQ_HALT);
    end

    // R6
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> halt_o);

    // R6
    halt_no_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> !branch_o);

    // R11
    branch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        branch_o |=> !branch_o);

    // R5
    ctrl_vec_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_o && vec_o == CTRL_VEC) |-> $past(ret_i));

    // R4
    ctrl_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SQ_RUN && mode_i == PM_CONTROL && !ret_i) |=> !branch_o);
endmodule

// File: rtl/psi_ctrl.sv
module psi_ctrl
    import psi_pkg::*;
#(
    parameter int                VEC_W    = 24,
    parameter logic [VEC_W-1:0]  NORM_VEC = 24'h000100,
    parameter logic [VEC_W-1:0]  CTRL_VEC = 24'h000094
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [NSRC-1:0]  irq_i,
    input  logic             instr_done_i,
    input  logic             ret_norm_i,
    input  logic [NSRC-1:0]  clr_i,
    output logic             branch_o,
    output logic [VEC_W-1:0] vector_o,
    output logic             clk_en_o,
    output logic [NSRC-1:0]  pend_o,
    output logic             store_rd_o
);
    pmode_t          mode;
    logic            halt;
    logic [NSRC-1:0] pend;

    assign mode = pmode_t'(mode_i);

    psi_pend #(.N(NSRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_i  (irq_i),
        .clr_i  (clr_i),
        .zb_i   (mode == PM_ZERO),
        .frz_i  (halt),
        .pend_o (pend),
        .rd_o   (store_rd_o)
    );

    psi_fsm #(
        .N        (NSRC),
        .VW       (VEC_W),
        .NORM_VEC (NORM_VEC),
        .CTRL_VEC (CTRL_VEC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .irq_i      (irq_i),
        .done_i     (instr_done_i),
        .ret_i      (ret_norm_i),
        .any_pend_i (|pend),
        .branch_o   (branch_o),
        .vec_o      (vector_o),
        .halt_o     (halt)
    );

    assign clk_en_o = !halt;
    assign pend_o   = pend;

    // R3
    norm_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_o && vector_o == NORM_VEC) |-> $past(instr_done_i && |pend));
endmodule

// File: tb/psi_ctrl_bench.sv
`timescale 1ns/1ps
module psi_ctrl_bench;
    localparam int N = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = 2'b00;
    logic [N-1:0]  irq_i = '0;
    logic          instr_done_i = 1'b0;
    logic          ret_norm_i = 1'b0;
    logic [N-1:0]  clr_i = '0;
    logic          branch_o;
    logic [23:0]   vector_o;
    logic          clk_en_o;
    logic [N-1:0]  pend_o;
    logic          store_rd_o;

    int checks = 0;
    int failures = 0;

    logic [N-1:0] m_pend;
    logic         m_frz, m_br, m_rd;
    logic [23:0]  m_vec;

    always #4 clk = ~clk;

    psi_ctrl u_psi_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .irq_i(irq_i),
        .instr_done_i(instr_done_i), .ret_norm_i(ret_norm_i), .clr_i(clr_i),
        .branch_o(branch_o), .vector_o(vector_o), .clk_en_o(clk_en_o),
        .pend_o(pend_o), .store_rd_o(store_rd_o)
    );

    function automatic logic [N-1:0] next_pend(logic [N-1:0] p, logic [1:0] md,
                                               logic [N-1:0] irq, logic [N-1:0] clr);
        logic [N-1:0] s;
        s = irq;
        if (md == 2'b10) s[6] = 1'b0;
        return (p & ~clr) | s;
    endfunction

    function automatic logic is_fatal(logic [1:0] md, logic [N-1:0] irq);
        return (md == 2'b10) && (|irq[5:0]);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk({tag, " branch"}, {31'd0, branch_o}, {31'd0, m_br});
        chk({tag, " vector"}, {8'd0, vector_o}, {8'd0, m_vec});
        chk({tag, " clk_en"}, {31'd0, clk_en_o}, {31'd0, !m_frz});
        chk({tag, " pend"}, {23'd0, pend_o}, {23'd0, m_pend});
        chk({tag, " store_rd"}, {31'd0, store_rd_o}, {31'd0, m_rd});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        mode_i = 2'b00; irq_i = '0; instr_done_i = 1'b0; ret_norm_i = 1'b0; clr_i = '0;
        m_pend = '0; m_frz = 1'b0; m_br = 1'b0; m_rd = 1'b0; m_vec = '0;
        @(negedge clk); @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");
    endtask

    task automatic step(string tag, logic [1:0] md, logic [N-1:0] irq,
                        logic dn, logic rt, logic [N-1:0] clr);
        logic fat, br;
        mode_i = md; irq_i = irq; instr_done_i = dn; ret_norm_i = rt; clr_i = clr;
        if (!m_frz) begin
            fat = is_fatal(md, irq);
            br  = !fat && !m_br && (|m_pend) &&
                  ((md == 2'b00 && dn) || ((md == 2'b01 || md == 2'b11) && rt));
            m_vec  = br ? ((md == 2'b00) ? 24'h000100 : 24'h000094) : 24'h0;
            m_br   = br;
            m_rd   = irq[8];
            m_pend = next_pend(m_pend, md, irq, clr);
            m_frz  = fat;
        end else begin
            m_br = 1'b0; m_vec = '0; m_rd = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        // R2 set and hold, R3 normal branch
        step("R2 tick set", 2'b00, 9'h080, 1'b0, 1'b0, 9'h000);
        step("R2 hold", 2'b00, 9'h000, 1'b0, 1'b0, 9'h000);
        step("R3 boundary", 2'b00, 9'h000, 1'b1, 1'b0, 9'h000);
        step("R11 boundary during branch", 2'b00, 9'h000, 1'b1, 1'b0, 9'h000);
        step("R3 again", 2'b00, 9'h000, 1'b1, 1'b0, 9'h000);
        step("R2 clear", 2'b00, 9'h000, 1'b0, 1'b0, 9'h080);
        step("R3 no pending", 2'b00, 9'h000, 1'b1, 1'b0, 9'h000);
        // R4 / R5 control mode
        step("R8 parity in control", 2'b01, 9'h001, 1'b0, 1'b0, 9'h000);
        step("R4 done in control", 2'b01, 9'h000, 1'b1, 1'b0, 9'h000);
        step("R4 done in code 11", 2'b11, 9'h000, 1'b1, 1'b0, 9'h000);
        step("R5 return with pending", 2'b01, 9'h000, 1'b0, 1'b1, 9'h000);
        step("R5 idle", 2'b01, 9'h000, 1'b0, 1'b0, 9'h1FF);
        step("R5 return empty", 2'b01, 9'h000, 1'b0, 1'b1, 9'h000);
        // R10 set wins over clear
        step("R10 set with clear", 2'b00, 9'h010, 1'b0, 1'b0, 9'h010);
        step("R8 fatal in normal", 2'b00, 9'h004, 1'b0, 1'b0, 9'h000);
        step("R2 clear all", 2'b00, 9'h000, 1'b0, 1'b0, 9'h1FF);
        // R7 privileged in zero-base, R8 tick/io no branch there
        step("R7 priv zero-base", 2'b10, 9'h040, 1'b0, 1'b0, 9'h000);
        step("R7 priv normal", 2'b00, 9'h040, 1'b0, 1'b0, 9'h000);
        step("R9 io in zero-base", 2'b10, 9'h180, 1'b1, 1'b0, 9'h000);
        step("R8 no branch in zero-base", 2'b10, 9'h000, 1'b1, 1'b1, 9'h000);
        // R11 freeze during branch cycle
        step("R11 take branch", 2'b00, 9'h000, 1'b1, 1'b0, 9'h000);
        step("R11 fatal in branch cycle", 2'b10, 9'h020, 1'b0, 1'b0, 9'h000);
        // R6 frozen
        step("R6 irq ignored", 2'b10, 9'h1FF, 1'b0, 1'b0, 9'h000);
        step("R6 clear ignored", 2'b00, 9'h000, 1'b1, 1'b0, 9'h1FF);
        step("R6 stays frozen", 2'b01, 9'h000, 1'b0, 1'b1, 9'h000);
        do_reset();
        step("R6 fatal addr", 2'b10, 9'h002, 1'b0, 1'b0, 9'h000);
        step("R6 frozen hold", 2'b00, 9'h100, 1'b1, 1'b0, 9'h002);
        // random segments
        void'($urandom(32'd5150));
        for (int seg = 0; seg < 8; seg++) begin
            do_reset();
            for (int c = 0; c < 500; c++) begin
                logic [N-1:0] irq, clr;
                logic [1:0] md;
                int r;
                r = $urandom_range(0, 99);
                md = (r < 45) ? 2'b00 : (r < 85) ? 2'b01 : (r < 88) ? 2'b11 : 2'b10;
                for (int b = 0; b < N; b++) irq[b] = ($urandom_range(0, 24) == 0);
                for (int b = 0; b < N; b++) clr[b] = ($urandom_range(0, 15) == 0);
                step("R2/R3/R5/R6/R9 random", md, irq,
                     $urandom_range(0, 3) == 0, $urandom_range(0, 5) == 0, clr);
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule